// File: doc/BRIEF.md
# Soft Reset Generator with Cause Capture

This block issues reset pulses to up to four processors and to the whole system. Two kinds of pulse exist. A power-on reset (POR) goes to one processor or to all of them together with a system reset. An externally initiated reset (XIR) goes to one processor or to every processor. Software starts either kind by writing a byte over a simple register bus. External lines can also start them: watchdog, push-button, JTAG requests, power-up, seven fatal-error lines, a remote monitor, and a clock-synthesizer load condition.

Each time a reset event happens, the block clears a source register and then records in it the cause or causes of that event. This happens separately for POR and for XIR. The source registers are not touched by the pulses the block sends out, so software can read them after the reset to find out why it happened. External lines act only on their rising edge. The watchdog can reset the system only after software has armed it. Fatal errors from agents 0 to 3 can each be masked.

Top module: `soft_reset_ctrl`

## Requirements
- R1: A write to address 0x0 with any of data bits 3:0 set pulses `proc_por_o` for the matching processors. The pulse starts in the first cycle after the write and lasts exactly PULSE_LEN (8) cycles. `sys_por_o` stays low.
- R2: A system POR event pulses `sys_por_o` and all four `proc_por_o` bits for PULSE_LEN cycles. The following are system POR events: bit 4 of a write to 0x0, a rising edge on jtag_por, button, powerup or remote, an unmasked fatal error, an armed watchdog, and a synthesizer reset.
- R3: An XIR request pulses `proc_xir_o` for PULSE_LEN cycles and does not touch the POR outputs. A write to 0x1 with bits 3:0 set sends XIR to the matching processors. A rising edge on `jtag_xir_i` or `xir_ext_i` sends XIR to all four.
- R4: Writes to reserved bits have no effect, and reserved bits read as zero. The reserved bits are bits 7:5 at 0x0, bits 7:4 at 0x1, bits 7:1 at 0x2, bits 3:0 at 0x3, and bits 6:1 at 0x4. Writes to the source addresses 0x8 to 0xB are ignored. Addresses 0x0 and 0x1 read as zero.
- R5: Bit 0 at 0x2 arms the watchdog. When it is set, a rising edge on `wdog_i` causes a system reset. When it is clear, the watchdog line has no effect.
- R6: Bits 7:4 at 0x3 mask fatal errors 0 to 3. A masked fatal error neither resets nor changes the POR source. Fatal errors 4 to 6 cannot be masked.
- R7: At 0x4, bit 0 is the synthesizer load bit and bit 7 enables reset on load. A system reset fires when both bits become 1.
- R8: The POR source is 18 bits and reads as bytes at 0x8, 0x9 and 0xA. Bit layout: bits 3:0 are per-processor soft resets, bit 4 soft system, bit 5 JTAG, bit 6 button, bit 7 power-up, bits 14:8 fatal errors 0 to 6, bit 15 synthesizer, bit 16 watchdog, bit 17 remote. On each POR event the register is cleared and only the causes of that event are set. It holds its value when no event occurs.
- R9: The XIR source reads at 0xB. Bits 3:0 are per-processor soft requests, bit 4 is JTAG and bit 5 is the external line. The register is cleared and reloaded on each XIR event, and POR events leave it unchanged.
- R10: A power-up edge sets the POR source to 0x00080, whatever else happens in the same cycle, and clears the XIR source.
- R11: After `rst_ni` is asserted, all outputs and both source registers are zero.
- R12: An external line held high causes exactly one event, on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| wdog_i | input | 1 | Watchdog expiry line |
| button_i | input | 1 | Reset push-button |
| jtag_por_i | input | 1 | JTAG system-reset request |
| powerup_i | input | 1 | Power-up event |
| fatal_i | input | 7 | Fatal-error lines from agents 0 to 6 |
| remote_i | input | 1 | Remote monitor reset request |
| jtag_xir_i | input | 1 | JTAG XIR-to-all request |
| xir_ext_i | input | 1 | External XIR request line |
| proc_por_o | output | 4 | Per-processor POR pulses |
| sys_por_o | output | 1 | System reset pulse |
| proc_xir_o | output | 4 | Per-processor XIR pulses |

## Verification
Soft POR and XIR writes are tried with one processor, with several processors, and with only reserved bits set. This tells per-processor routing apart from system-wide routing and from bits that must be ignored. The watchdog and the maskable fatal lines are each driven twice, once blocked and once allowed, so that a gating fault shows up as a missing pulse or as an unexpected one. Several simultaneous causes, power-up combined with another cause, and a line held high for many cycles separate three behaviours: clear-then-set capture, power-up priority, and edge-only triggering. The source bytes are read after each event.

// File: rtl/soft_reset_pkg.sv
package soft_reset_pkg;
  localparam int NPROC     = 4;
  localparam int FATAL_W   = 7;
  localparam int NMASK     = 4;
  localparam int POR_SRC_W = 18;
  localparam int XIR_SRC_W = 6;
  localparam int SOFT_POR_W = NPROC + 1;

  localparam logic [3:0] A_SOFT_POR = 4'h0;
  localparam logic [3:0] A_SOFT_XIR = 4'h1;
  localparam logic [3:0] A_WDOG     = 4'h2;
  localparam logic [3:0] A_FMASK    = 4'h3;
  localparam logic [3:0] A_SYNTH    = 4'h4;
  localparam logic [3:0] A_PSRC0    = 4'h8;
  localparam logic [3:0] A_PSRC1    = 4'h9;
  localparam logic [3:0] A_PSRC2    = 4'hA;
  localparam logic [3:0] A_XSRC     = 4'hB;

  localparam int P_SOFT_SYS = 4;
  localparam int P_PWRUP    = 7;
  localparam int P_WDOG     = 16;
  localparam logic [POR_SRC_W-1:0] PWRUP_ONLY = 18'h00080;
endpackage

// File: rtl/soft_reset_regs.sv
module soft_reset_regs
  import soft_reset_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [3:0]             addr_i,
  input  logic [7:0]             wdata_i,
  input  logic [POR_SRC_W-1:0]   por_src_i,
  input  logic [XIR_SRC_W-1:0]   xir_src_i,
  output logic [7:0]             rdata_o,
  output logic [SOFT_POR_W-1:0]  soft_por_o,
  output logic [NPROC-1:0]       soft_xir_o,
  output logic                   wdog_arm_o,
  output logic [NMASK-1:0]       fatal_mask_o,
  output logic                   synth_trig_o
);
  logic             wdog_arm_q;
  logic [NMASK-1:0] fmask_q;
  logic             load_q, load_rst_en_q;

  // trigger registers are strobes; only defined bits pass
  assign soft_por_o = (we_i && addr_i == A_SOFT_POR) ? wdata_i[SOFT_POR_W-1:0] : '0;
  assign soft_xir_o = (we_i && addr_i == A_SOFT_XIR) ? wdata_i[NPROC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdog_arm_q    <= 1'b0;
      fmask_q       <= '0;
      load_q        <= 1'b0;
      load_rst_en_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_WDOG:  wdog_arm_q <= wdata_i[0];
        A_FMASK: fmask_q    <= wdata_i[7:8-NMASK];
        A_SYNTH: begin
          load_q        <= wdata_i[0];
          load_rst_en_q <= wdata_i[7];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_WDOG:  rdata_o = {7'b0, wdog_arm_q};
      A_FMASK: rdata_o = {fmask_q, {(8-NMASK){1'b0}}};
      A_SYNTH: rdata_o = {load_rst_en_q, 6'b0, load_q};
      A_PSRC0: rdata_o = por_src_i[7:0];
      A_PSRC1: rdata_o = por_src_i[15:8];
      A_PSRC2: rdata_o = {6'b0, por_src_i[17:16]};
      A_XSRC:  rdata_o = {2'b0, xir_src_i};
      default: rdata_o = 8'h00;
    endcase
  end

  assign wdog_arm_o   = wdog_arm_q;
  assign fatal_mask_o = fmask_q;
  assign synth_trig_o = load_q & load_rst_en_q;

  // R4
  wdog_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_WDOG) |=> (wdog_arm_o == $past(wdata_i[0])));
endmodule

// File: rtl/soft_reset_events.sv
module soft_reset_events
  import soft_reset_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SOFT_POR_W-1:0]  soft_por_i,
  input  logic [NPROC-1:0]       soft_xir_i,
  input  logic                   wdog_arm_i,
  input  logic [NMASK-1:0]       fatal_mask_i,
  input  logic                   synth_trig_i,
  input  logic                   wdog_i,
  input  logic                   button_i,
  input  logic                   jtag_por_i,
  input  logic                   powerup_i,
  input  logic [FATAL_W-1:0]     fatal_i,
  input  logic                   remote_i,
  input  logic                   jtag_xir_i,
  input  logic                   xir_ext_i,
  output logic [POR_SRC_W-1:0]   por_ev_o,
  output logic [XIR_SRC_W-1:0]   xir_ev_o
);
  localparam int L_WDOG = FATAL_W;
  localparam int L_BTN  = FATAL_W + 1;
  localparam int L_JTAG = FATAL_W + 2;
  localparam int L_PWR  = FATAL_W + 3;
  localparam int L_REM  = FATAL_W + 4;
  localparam int L_SYN  = FATAL_W + 5;
  localparam int L_JXIR = FATAL_W + 6;
  localparam int L_XEXT = FATAL_W + 7;
  localparam int LVL_W  = FATAL_W + 8;

  logic [LVL_W-1:0]   lvl, prev_q, rise;
  logic [FATAL_W-1:0] fatal_ev;

  assign lvl = {xir_ext_i, jtag_xir_i, synth_trig_i, remote_i, powerup_i,
                jtag_por_i, button_i, wdog_i, fatal_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  for (genvar i = 0; i < FATAL_W; i++) begin : g_fatal
    if (i < NMASK) begin : g_maskable
      assign fatal_ev[i] = rise[i] & ~fatal_mask_i[i];
    end else begin : g_fixed
      assign fatal_ev[i] = rise[i];
    end
  end

  assign por_ev_o = {rise[L_REM], rise[L_WDOG] & wdog_arm_i, rise[L_SYN], fatal_ev,
                     rise[L_PWR], rise[L_BTN], rise[L_JTAG], soft_por_i};
  assign xir_ev_o = {rise[L_XEXT], rise[L_JXIR], soft_xir_i};

  // R12
  held_line_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (button_i && $past(button_i)) |-> !por_ev_o[6]);
endmodule

// File: rtl/soft_reset_capture.sv
module soft_reset_capture
  import soft_reset_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [POR_SRC_W-1:0] por_ev_i,
  input  logic [XIR_SRC_W-1:0] xir_ev_i,
  output logic [POR_SRC_W-1:0] por_src_o,
  output logic [XIR_SRC_W-1:0] xir_src_o
);
  logic [POR_SRC_W-1:0] por_q;
  logic [XIR_SRC_W-1:0] xir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= '0;
      xir_q <= '0;
    end else if (por_ev_i[P_PWRUP]) begin
      por_q <= PWRUP_ONLY;
      xir_q <= '0;
    end else begin
      if (|por_ev_i) por_q <= por_ev_i;
      if (|xir_ev_i) xir_q <= xir_ev_i;
    end
  end

  assign por_src_o = por_q;
  assign xir_src_o = xir_q;

  // R10
  pwrup_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_ev_i[P_PWRUP] |=> (por_src_o == PWRUP_ONLY && xir_src_o == '0));
  // R8
  por_src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|por_ev_i) |=> $stable(por_src_o));
  // R9
  xir_src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|xir_ev_i) && !por_ev_i[P_PWRUP]) |=> $stable(xir_src_o));
endmodule

// File: rtl/soft_reset_pulse.sv
module soft_reset_pulse #(
  parameter int N   = 4,
  parameter int LEN = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] out_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [CW-1:0] cnt_q;

    // retrigger restarts the full window
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (trig_i[i])      cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign out_o[i] = (cnt_q != '0);

    // R1
    pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i[i] |=> out_o[i]);
    // R1
    no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!out_o[i] && !trig_i[i]) |=> !out_o[i]);
    // R1
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LOAD);
  end
endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
  import soft_reset_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [3:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic               wdog_i,
  input  logic               button_i,
  input  logic               jtag_por_i,
  input  logic               powerup_i,
  input  logic [FATAL_W-1:0] fatal_i,
  input  logic               remote_i,
  input  logic               jtag_xir_i,
  input  logic               xir_ext_i,
  output logic [NPROC-1:0]   proc_por_o,
  output logic               sys_por_o,
  output logic [NPROC-1:0]   proc_xir_o
);
  logic [SOFT_POR_W-1:0] soft_por;
  logic [NPROC-1:0]      soft_xir;
  logic                  wdog_arm, synth_trig;
  logic [NMASK-1:0]      fatal_mask;
  logic [POR_SRC_W-1:0]  por_ev, por_src;
  logic [XIR_SRC_W-1:0]  xir_ev, xir_src;
  logic                  sys_ev;
  logic [NPROC:0]        por_trig, por_pulse;
  logic [NPROC-1:0]      xir_trig;

  soft_reset_regs u_regs (
    .clk_i, .rst_ni,
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .por_src_i    (por_src),
    .xir_src_i    (xir_src),
    .rdata_o      (bus_rdata_o),
    .soft_por_o   (soft_por),
    .soft_xir_o   (soft_xir),
    .wdog_arm_o   (wdog_arm),
    .fatal_mask_o (fatal_mask),
    .synth_trig_o (synth_trig)
  );

  soft_reset_events u_events (
    .clk_i, .rst_ni,
    .soft_por_i   (soft_por),
    .soft_xir_i   (soft_xir),
    .wdog_arm_i   (wdog_arm),
    .fatal_mask_i (fatal_mask),
    .synth_trig_i (synth_trig),
    .wdog_i, .button_i, .jtag_por_i, .powerup_i, .fatal_i, .remote_i,
    .jtag_xir_i, .xir_ext_i,
    .por_ev_o     (por_ev),
    .xir_ev_o     (xir_ev)
  );

  soft_reset_capture u_capture (
    .clk_i, .rst_ni,
    .por_ev_i  (por_ev),
    .xir_ev_i  (xir_ev),
    .por_src_o (por_src),
    .xir_src_o (xir_src)
  );

  assign sys_ev = |por_ev[POR_SRC_W-1:P_SOFT_SYS];

  for (genvar i = 0; i < NPROC; i++) begin : g_route
    assign por_trig[i] = por_ev[i] | sys_ev;
    assign xir_trig[i] = xir_ev[i] | xir_ev[NPROC] | xir_ev[NPROC+1];
  end
  assign por_trig[NPROC] = sys_ev;

  soft_reset_pulse #(.N(NPROC + 1), .LEN(PULSE_LEN)) u_por_pulse (
    .clk_i, .rst_ni, .trig_i(por_trig), .out_o(por_pulse)
  );

  soft_reset_pulse #(.N(NPROC), .LEN(PULSE_LEN)) u_xir_pulse (
    .clk_i, .rst_ni, .trig_i(xir_trig), .out_o(proc_xir_o)
  );

  assign proc_por_o = por_pulse[NPROC-1:0];
  assign sys_por_o  = por_pulse[NPROC];

  // R2
  sys_all_proc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_por_o |-> (&proc_por_o));
  // R5
  wdog_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_src[P_WDOG]) |-> $past(wdog_arm));
endmodule

// File: tb/soft_reset_ctrl_tb.sv
module soft_reset_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [3:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0, bus_rdata_o;
  logic       wdog_i = 0, button_i = 0, jtag_por_i = 0, powerup_i = 0;
  logic [6:0] fatal_i = '0;
  logic       remote_i = 0, jtag_xir_i = 0, xir_ext_i = 0;
  logic [3:0] proc_por_o, proc_xir_o;
  logic       sys_por_o;

  int checks = 0, failures = 0;
  int sys_hi, por_hi, xir_hi;
  logic [3:0] por_seen, xir_seen;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  soft_reset_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic rd_por(output logic [17:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'h8, b0); rd(4'h9, b1); rd(4'hA, b2);
    v = {b2[1:0], b1, b0};
  endtask

  // sample outputs at n consecutive falling edges, starting at the current one
  task automatic watch(input int n);
    sys_hi = 0; por_hi = 0; xir_hi = 0; por_seen = '0; xir_seen = '0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk_i);
      if (sys_por_o) sys_hi++;
      if (|proc_por_o) por_hi++;
      if (|proc_xir_o) xir_hi++;
      por_seen |= proc_por_o;
      xir_seen |= proc_xir_o;
    end
  endtask

  // m: 0 wdog, 1 button, 2 jtag_por, 3 powerup, 4 remote, 5 jtag_xir, 6 xir_ext
  task automatic ext(input logic [6:0] m, input logic [6:0] f);
    @(negedge clk_i);
    {xir_ext_i, jtag_xir_i, remote_i, powerup_i, jtag_por_i, button_i, wdog_i} = m;
    fatal_i = f;
    @(posedge clk_i);
    @(negedge clk_i);
    {xir_ext_i, jtag_xir_i, remote_i, powerup_i, jtag_por_i, button_i, wdog_i} = '0;
    fatal_i = '0;
  endtask

  task automatic t_reset();
    logic [17:0] p; logic [7:0] x;
    @(negedge clk_i);
    chk("R11 por outputs", {sys_por_o, proc_por_o, proc_xir_o}, 0);
    rd_por(p); rd(4'hB, x);
    chk("R11 por source", p, 0);
    chk("R11 xir source", x, 0);
  endtask

  task automatic t_soft_por();
    logic [17:0] p;
    wr(4'h0, 8'h04); watch(12);
    chk("R1 pulse length", por_hi, 8);
    chk("R1 target proc", por_seen, 4'b0100);
    chk("R1 no system", sys_hi, 0);
    rd_por(p); chk("R8 soft proc cause", p, 18'h00004);
  endtask

  task automatic t_reserved();
    logic [17:0] p; logic [7:0] d;
    wr(4'h0, 8'hE0); watch(12);
    chk("R4 reserved soft por bits", por_hi, 0);
    rd_por(p); chk("R4 source unchanged", p, 18'h00004);
    wr(4'h8, 8'hFF); wr(4'hA, 8'hFF);
    rd_por(p); chk("R4 source read-only", p, 18'h00004);
    wr(4'h2, 8'hFE); rd(4'h2, d); chk("R4 arm reserved", d, 8'h00);
    wr(4'h4, 8'h7E); rd(4'h4, d); chk("R4 synth reserved", d, 8'h00);
    rd(4'h0, d); chk("R4 trigger reads zero", d, 8'h00);
    wr(4'h1, 8'hF0); watch(12);
    chk("R4 reserved soft xir bits", xir_hi, 0);
  endtask

  task automatic t_soft_sys();
    logic [17:0] p;
    wr(4'h0, 8'h10); watch(12);
    chk("R2 system pulse", sys_hi, 8);
    chk("R2 all procs", por_seen, 4'hF);
    rd_por(p); chk("R8 clear then set", p, 18'h00010);
  endtask

  task automatic t_wdog();
    logic [17:0] p; logic [7:0] d;
    ext(7'h01, 7'h00); watch(12);
    chk("R5 unarmed ignored", sys_hi + por_hi, 0);
    rd_por(p); chk("R5 unarmed no cause", p, 18'h00010);
    wr(4'h2, 8'h01); rd(4'h2, d); chk("R5 arm readback", d, 8'h01);
    ext(7'h01, 7'h00); watch(12);
    chk("R5 armed reset", sys_hi, 8);
    rd_por(p); chk("R8 watchdog cause", p, 18'h10000);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_fatal();
    logic [17:0] p; logic [7:0] d;
    wr(4'h3, 8'h1F); rd(4'h3, d); chk("R6 mask readback", d, 8'h10);
    ext(7'h00, 7'h01); watch(12);
    chk("R6 masked no reset", sys_hi, 0);
    rd_por(p); chk("R6 masked no log", p, 18'h10000);
    ext(7'h00, 7'h02); watch(12);
    chk("R6 unmasked reset", sys_hi, 8);
    rd_por(p); chk("R8 fatal1 cause", p, 18'h00200);
    wr(4'h3, 8'hF0);
    ext(7'h00, 7'h40); watch(12);
    chk("R6 fatal6 unmaskable", sys_hi, 8);
    rd_por(p); chk("R8 fatal6 cause", p, 18'h04000);
    wr(4'h3, 8'h00);
  endtask

  task automatic t_synth();
    logic [17:0] p;
    wr(4'h4, 8'h01); watch(12);
    chk("R7 load without enable", sys_hi, 0);
    wr(4'h4, 8'h81); watch(12);
    chk("R7 synth reset", sys_hi, 8);
    rd_por(p); chk("R8 synth cause", p, 18'h08000);
    wr(4'h4, 8'h00);
  endtask

  task automatic t_multi();
    logic [17:0] p;
    ext(7'h16, 7'h00); watch(12);
    chk("R2 multi system pulse", sys_hi, 8);
    rd_por(p); chk("R8 multi cause", p, 18'h20060);
  endtask

  task automatic t_xir();
    logic [17:0] p; logic [7:0] x;
    wr(4'h1, 8'h03); watch(12);
    chk("R3 xir length", xir_hi, 8);
    chk("R3 xir targets", xir_seen, 4'b0011);
    chk("R3 no por", por_hi, 0);
    rd(4'hB, x); chk("R9 soft xir cause", x, 8'h03);
    rd_por(p); chk("R9 por source untouched", p, 18'h20060);
    ext(7'h20, 7'h00); watch(12);
    chk("R3 jtag xir all", xir_seen, 4'hF);
    rd(4'hB, x); chk("R9 jtag xir cause", x, 8'h10);
    ext(7'h40, 7'h00); watch(12);
    chk("R3 ext xir all", xir_seen, 4'hF);
    rd(4'hB, x); chk("R9 ext xir cause", x, 8'h20);
    wr(4'h0, 8'h01); watch(12);
    rd(4'hB, x); chk("R9 por keeps xir source", x, 8'h20);
  endtask

  task automatic t_hold();
    logic [17:0] p;
    @(negedge clk_i); button_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    watch(30);
    chk("R12 held line one pulse", sys_hi, 8);
    button_i = 1'b0;
    rd_por(p); chk("R12 button cause", p, 18'h00040);
  endtask

  task automatic t_powerup();
    logic [17:0] p; logic [7:0] x;
    ext(7'h0A, 7'h02); watch(12);
    chk("R10 powerup resets system", sys_hi, 8);
    rd_por(p); chk("R10 powerup only", p, 18'h00080);
    rd(4'hB, x); chk("R10 xir cleared", x, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk_i);
        failures++; checks++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_soft_por();
    t_reserved();
    t_soft_sys();
    t_wdog();
    t_fatal();
    t_synth();
    t_multi();
    t_xir();
    t_hold();
    t_powerup();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule